// File: doc/BRIEF.md
# Two-Thread Priority Slot Arbiter

This block decides, every clock cycle, which of two hardware threads sharing one core pipeline receives the single fetch/dispatch slot. Each thread presents a ready flag, a software-set priority of eight levels, and the number of shared back-end entries it currently holds, such as completion-table slots or rename buffers. One shared threshold applies to both occupancy counts. The arbiter returns a one-hot grant and the index of the granted thread. Both outputs are combinational from the current inputs and from the state registered at the previous edge.

When both threads compete at equal priority, the slot alternates every cycle. When their priorities differ, the grant ratio tilts toward the higher-priority thread by a power of two. A thread whose occupancy has reached the threshold is held back while the other thread can still use the slot. This keeps one thread from filling the shared entries and starving its sibling. Priority zero parks a thread.

Top module: `smt_slot_arbiter`

## Requirements
- R1: `grant_o` is one-hot or all zero. Bit 0 stands for thread 0 and bit 1 for thread 1. `grant_tid_o` equals the index of the granted thread, and it is 0 when no grant is given.
- R2: A thread is eligible only when its ready bit is 1 and its 3-bit priority is non-zero. A thread at priority 0 is never granted.
- R3: When exactly one thread is eligible, that thread is granted every cycle, whatever the priorities and occupancy counts.
- R4: Consider cycles where both threads are eligible, both have equal priority, and both occupancies are below the threshold. In these cycles the grant goes to the thread other than the one granted most recently, so the slot alternates every cycle.
- R5: Consider cycles where both threads are eligible and under the threshold but their priorities differ. Let d be the priority difference, capped at 5. The higher-priority thread receives 2^d consecutive grants, then the lower-priority thread receives one, and the pattern repeats.
- R6: Suppose a thread's occupancy is greater than or equal to `occ_limit_i` while the other thread is eligible and below the limit. The over-limit thread is then not granted; the other thread gets the slot. Arbitration by R4 or R5 resumes once the count falls below the limit.
- R7: When both threads are eligible and both are at or above the limit, the grant alternates as in R4, regardless of priority.
- R8: After synchronous reset, the first alternating grant goes to thread 0, and the ratio run of R5 starts from zero.
- R9: Any cycle that does not fall under R5 clears the ratio run. The next R5 cycle therefore starts a full run of 2^d higher-priority grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready_i | input | 2 | Per-thread ready, bit t for thread t |
| thr0_prio_i | input | PRIO_W | Thread 0 priority (0 = parked) |
| thr1_prio_i | input | PRIO_W | Thread 1 priority (0 = parked) |
| thr0_occ_i | input | OCC_W | Shared entries held by thread 0 |
| thr1_occ_i | input | OCC_W | Shared entries held by thread 1 |
| occ_limit_i | input | OCC_W | Occupancy threshold shared by both threads |
| grant_o | output | 2 | One-hot grant |
| grant_tid_o | output | 1 | Granted thread index |

## Verification
Every grant is due in the same cycle as the inputs that cause it. The alternation pointer and the ratio run advance only at the following rising edge, so each cycle's result depends on that cycle's inputs plus the grants already given. The bench therefore changes inputs on the falling edge and samples the outputs 1 ns later, before the next rising edge. Each sample is compared with a pattern the bench derives from the requirements: a running record of the last granted thread, and a position inside the 2^d+1 ratio period counted from the first cycle of a run.

// File: rtl/smtarb_pkg.sv
package smtarb_pkg;

    localparam int THREADS   = 2;
    localparam int MAX_SHIFT = 5;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
    localparam int QUOTA_W   = MAX_SHIFT + 1;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_SOLO = 2'd1,
        MODE_ALT  = 2'd2,
        MODE_SKEW = 2'd3
    } arb_mode_e;

    typedef struct packed {
        arb_mode_e          mode;
        logic               solo_tid;
        logic               hi_tid;
        logic [SHIFT_W-1:0] shift;
    } arb_plan_t;

    function automatic logic [QUOTA_W-1:0] run_quota(input logic [SHIFT_W-1:0] sh);
        return QUOTA_W'(1) << sh;
    endfunction

endpackage

// File: rtl/smtarb_classify.sv
module smtarb_classify
    import smtarb_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int OCC_W  = 6
) (
    input  logic [THREADS-1:0]             ready_i,
    input  logic [THREADS-1:0][PRIO_W-1:0] prio_i,
    input  logic [THREADS-1:0][OCC_W-1:0]  occ_i,
    input  logic [OCC_W-1:0]               limit_i,
    output arb_plan_t                      plan_o
);

    logic [THREADS-1:0] elig;
    logic [THREADS-1:0] over;
    logic [THREADS-1:0] cand;
    logic               both_over;
    logic               hi;
    logic [PRIO_W-1:0]  diff;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        assign elig[t] = ready_i[t] && (prio_i[t] != '0);
        assign over[t] = occ_i[t] >= limit_i;
    end

    always_comb begin
        both_over = (elig == 2'b11) && (over == 2'b11);
        cand      = elig & ~over;
        if (cand == '0) begin
            cand = elig;
        end
        hi   = prio_i[1] > prio_i[0];
        diff = hi ? (prio_i[1] - prio_i[0]) : (prio_i[0] - prio_i[1]);

        plan_o          = '0;
        plan_o.hi_tid   = hi;
        plan_o.shift    = (diff > PRIO_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : SHIFT_W'(diff);
        case (cand)
            2'b00: plan_o.mode = MODE_IDLE;
            2'b01: begin
                plan_o.mode     = MODE_SOLO;
                plan_o.solo_tid = 1'b0;
            end
            2'b10: begin
                plan_o.mode     = MODE_SOLO;
                plan_o.solo_tid = 1'b1;
            end
            default: plan_o.mode = (both_over || diff == '0) ? MODE_ALT : MODE_SKEW;
        endcase
    end

endmodule

// File: rtl/smtarb_skew_counter.sv
module smtarb_skew_counter
    import smtarb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  arb_plan_t plan_i,
    output logic      pick_low_o
);

    logic [QUOTA_W-1:0] run_cnt;
    logic [QUOTA_W-1:0] quota;

    assign quota      = run_quota(plan_i.shift);
    assign pick_low_o = (plan_i.mode == MODE_SKEW) && (run_cnt >= quota);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (plan_i.mode != MODE_SKEW || pick_low_o) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + QUOTA_W'(1);
        end
    end

endmodule

// File: rtl/smtarb_grant_select.sv
module smtarb_grant_select
    import smtarb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  arb_plan_t          plan_i,
    input  logic               pick_low_i,
    output logic [THREADS-1:0] grant_o,
    output logic               tid_o
);

    logic last_tid;
    logic fire;

    always_comb begin
        fire  = 1'b1;
        tid_o = 1'b0;
        case (plan_i.mode)
            MODE_SOLO: tid_o = plan_i.solo_tid;
            MODE_ALT:  tid_o = ~last_tid;
            MODE_SKEW: tid_o = pick_low_i ? ~plan_i.hi_tid : plan_i.hi_tid;
            default:   fire  = 1'b0;
        endcase
        grant_o = fire ? (THREADS'(1) << tid_o) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_tid <= 1'b1;
        end else if (fire) begin
            last_tid <= tid_o;
        end
    end

endmodule

// File: rtl/smt_slot_arbiter.sv
module smt_slot_arbiter
    import smtarb_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int OCC_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        thr_ready_i,
    input  logic [PRIO_W-1:0] thr0_prio_i,
    input  logic [PRIO_W-1:0] thr1_prio_i,
    input  logic [OCC_W-1:0]  thr0_occ_i,
    input  logic [OCC_W-1:0]  thr1_occ_i,
    input  logic [OCC_W-1:0]  occ_limit_i,
    output logic [1:0]        grant_o,
    output logic              grant_tid_o
);

    logic [THREADS-1:0][PRIO_W-1:0] prio_vec;
    logic [THREADS-1:0][OCC_W-1:0]  occ_vec;
    arb_plan_t                      plan;
    logic                           pick_low;

    assign prio_vec = {thr1_prio_i, thr0_prio_i};
    assign occ_vec  = {thr1_occ_i, thr0_occ_i};

    smtarb_classify #(
        .PRIO_W (PRIO_W),
        .OCC_W  (OCC_W)
    ) classify_i (
        .ready_i (thr_ready_i),
        .prio_i  (prio_vec),
        .occ_i   (occ_vec),
        .limit_i (occ_limit_i),
        .plan_o  (plan)
    );

    smtarb_skew_counter skew_i (
        .clk        (clk),
        .rst        (rst),
        .plan_i     (plan),
        .pick_low_o (pick_low)
    );

    smtarb_grant_select select_i (
        .clk        (clk),
        .rst        (rst),
        .plan_i     (plan),
        .pick_low_i (pick_low),
        .grant_o    (grant_o),
        .tid_o      (grant_tid_o)
    );

endmodule

// File: rtl/smt_slot_arbiter_chk.sv
module smt_slot_arbiter_chk #(
    parameter int PRIO_W = 3,
    parameter int OCC_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        thr_ready_i,
    input logic [PRIO_W-1:0] thr0_prio_i,
    input logic [PRIO_W-1:0] thr1_prio_i,
    input logic [OCC_W-1:0]  thr0_occ_i,
    input logic [OCC_W-1:0]  thr1_occ_i,
    input logic [OCC_W-1:0]  occ_limit_i,
    input logic [1:0]        grant_o,
    input logic              grant_tid_o
);

    logic e0, e1, u0, u1, alt_now, alt_prev, prev_tid;

    assign e0      = thr_ready_i[0] && (thr0_prio_i != '0);
    assign e1      = thr_ready_i[1] && (thr1_prio_i != '0);
    assign u0      = thr0_occ_i < occ_limit_i;
    assign u1      = thr1_occ_i < occ_limit_i;
    assign alt_now = e0 && e1 && ((u0 && u1 && thr0_prio_i == thr1_prio_i) || (!u0 && !u1));

    always_ff @(posedge clk) begin
        if (rst) begin
            alt_prev <= 1'b0;
            prev_tid <= 1'b0;
        end else begin
            alt_prev <= alt_now && (grant_o != 2'b00);
            prev_tid <= grant_tid_o;
        end
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o) && (grant_o[1] == grant_tid_o));

    // R2
    parked_never_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o[0] |-> e0) and (grant_o[1] |-> e1));

    // R3
    solo_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (e0 != e1) |-> (grant_o == {e1, e0}));

    // R4, R7
    alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (alt_prev && alt_now) |-> (grant_tid_o != prev_tid));

    // R6
    throttle_chk: assert property (@(posedge clk) disable iff (rst)
        (e0 && e1 && (u0 != u1)) |-> (grant_o == {u1, u0}));

endmodule

bind smt_slot_arbiter smt_slot_arbiter_chk #(
    .PRIO_W (PRIO_W),
    .OCC_W  (OCC_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .thr_ready_i (thr_ready_i),
    .thr0_prio_i (thr0_prio_i),
    .thr1_prio_i (thr1_prio_i),
    .thr0_occ_i  (thr0_occ_i),
    .thr1_occ_i  (thr1_occ_i),
    .occ_limit_i (occ_limit_i),
    .grant_o     (grant_o),
    .grant_tid_o (grant_tid_o)
);

// File: tb/smt_slot_arbiter_tb_top.sv
module smt_slot_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ready = '0;
    logic [2:0] p0 = '0, p1 = '0;
    logic [5:0] o0 = '0, o1 = '0, lim = 6'd8;
    logic [1:0] grant;
    logic       tid;

    int checks = 0;
    int errors = 0;
    logic exp_last = 1'b1;

    always #2.5 clk = ~clk;

    smt_slot_arbiter dut_i (
        .clk         (clk),
        .rst         (rst),
        .thr_ready_i (ready),
        .thr0_prio_i (p0),
        .thr1_prio_i (p1),
        .thr0_occ_i  (o0),
        .thr1_occ_i  (o1),
        .occ_limit_i (lim),
        .grant_o     (grant),
        .grant_tid_o (tid)
    );

    task automatic drive(input logic [1:0] r, input logic [2:0] a, input logic [2:0] b,
                         input logic [5:0] x, input logic [5:0] y);
        @(negedge clk);
        ready = r; p0 = a; p1 = b; o0 = x; o1 = y;
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] exp_g);
        logic exp_t;
        exp_t = exp_g[1];
        checks++;
        if (grant !== exp_g || tid !== exp_t) begin
            errors++;
            $display("FAIL %s: grant=%b tid=%b expected grant=%b tid=%b", req, grant, tid, exp_g, exp_t);
        end
        if (exp_g != 2'b00) exp_last = exp_t;
    endtask

    function automatic logic [1:0] onehot(input logic t);
        return t ? 2'b10 : 2'b01;
    endfunction

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1 reset idle", 2'b00);
        @(negedge clk);
        rst = 1'b0; ready = 2'b11; p0 = 3'd3; p1 = 3'd3;
        #1;
        chk("R8 first grant thread0", 2'b01);
    endtask

    task automatic t_alternate(input logic [2:0] pr, input int n);
        for (int i = 0; i < n; i++) begin
            drive(2'b11, pr, pr, 6'd0, 6'd0);
            chk("R4 alternate", onehot(~exp_last));
        end
    endtask

    task automatic t_solo;
        for (int i = 0; i < 4; i++) begin
            drive(2'b01, 3'd2, 3'd7, 6'd63, 6'd0);
            chk("R3 solo thread0 over limit", 2'b01);
        end
        for (int i = 0; i < 3; i++) begin
            drive(2'b10, 3'd7, 3'd1, 6'd0, 6'd0);
            chk("R3 solo thread1 low prio", 2'b10);
        end
    endtask

    task automatic t_parked;
        for (int i = 0; i < 3; i++) begin
            drive(2'b11, 3'd0, 3'd2, 6'd0, 6'd0);
            chk("R2 thread0 parked", 2'b10);
        end
        drive(2'b11, 3'd0, 3'd0, 6'd0, 6'd0);
        chk("R2 both parked", 2'b00);
        drive(2'b00, 3'd5, 3'd5, 6'd0, 6'd0);
        chk("R1 none ready", 2'b00);
    endtask

    task automatic t_skew(input logic [2:0] a, input logic [2:0] b, input int periods);
        int d, q;
        logic hi;
        hi = b > a;
        d  = hi ? int'(b) - int'(a) : int'(a) - int'(b);
        if (d > 5) d = 5;
        q  = 1 << d;
        drive(2'b00, a, b, 6'd0, 6'd0);
        chk("R9 idle before run", 2'b00);
        for (int i = 0; i < periods * (q + 1); i++) begin
            drive(2'b11, a, b, 6'd0, 6'd0);
            chk("R5 ratio", onehot(((i % (q + 1)) < q) ? hi : ~hi));
        end
    endtask

    task automatic t_run_restart;
        drive(2'b00, 3'd6, 3'd4, 6'd0, 6'd0);
        chk("R9 idle", 2'b00);
        for (int i = 0; i < 2; i++) begin
            drive(2'b11, 3'd6, 3'd4, 6'd0, 6'd0);
            chk("R5 partial run", 2'b01);
        end
        drive(2'b01, 3'd6, 3'd4, 6'd0, 6'd0);
        chk("R9 break run", 2'b01);
        for (int i = 0; i < 5; i++) begin
            drive(2'b11, 3'd6, 3'd4, 6'd0, 6'd0);
            chk("R9 run restarts", (i < 4) ? 2'b01 : 2'b10);
        end
    endtask

    task automatic t_throttle;
        lim = 6'd10;
        for (int i = 0; i < 4; i++) begin
            drive(2'b11, 3'd7, 3'd1, 6'd12, 6'd3);
            chk("R6 thread0 held back", 2'b10);
        end
        for (int i = 0; i < 2; i++) begin
            drive(2'b11, 3'd4, 3'd4, 6'd2, 6'd10);
            chk("R6 thread1 held back at limit", 2'b01);
        end
        for (int i = 0; i < 4; i++) begin
            drive(2'b11, 3'd4, 3'd4, 6'd9, 6'd9);
            chk("R6 resume below limit", onehot(~exp_last));
        end
    endtask

    task automatic t_both_over;
        for (int i = 0; i < 6; i++) begin
            drive(2'b11, 3'd7, 3'd1, 6'd20, 6'd10);
            chk("R7 both over alternate", onehot(~exp_last));
        end
        lim = 6'd8;
    endtask

    initial begin
        t_reset();
        t_alternate(3'd3, 7);
        t_alternate(3'd7, 4);
        t_solo();
        t_parked();
        t_skew(3'd5, 3'd3, 3);
        t_skew(3'd4, 3'd5, 3);
        t_skew(3'd1, 3'd7, 2);
        t_run_restart();
        t_throttle();
        t_both_over();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule